// File: doc/BRIEF.md
# Reconfigurable Fixed-Point Processing Element

This block is one compute cell of a synchronous dataflow array. It has two modes. While the mode input is low, a small write port loads the cell's setup: two signed coefficients, an operation selector and a firing pattern. While the mode input is high, the cell takes three signed 16-bit operands on every clock. It then computes one of four arithmetic forms and clamps the result to 16 bits.

The firing pattern is a 16-bit mask that a pointer walks through, one entry per runtime clock. The cell produces a fresh result only on clocks whose mask bit is set. On the other clocks it keeps its last result and drops its valid flag. This lets an array builder run a cell at a fraction of the input rate, for example to decimate a filter-bank branch, without any extra control logic.

Top module: `pe_elem`

## Requirements
- R1: After reset, resOut is 0 and resValid is 0. Both coefficients, the operation and the firing mask are also 0, so no runtime cycle fires until a mask is written.
- R2: While runMode is 0, a write with cfgWe high stores cfgData into the register chosen by cfgAddr: 0 is coefficient A, 1 is coefficient B, 2 is the operation (taken from cfgData[1:0]), and 3 is the firing mask.
- R3: While runMode is 1, cfgWe has no effect on any setup register.
- R4: Operation code 0 yields X*A + Y.
- R5: Operation code 1 yields X*A + Y*B + W.
- R6: Operation code 2 yields X + Y.
- R7: Operation code 3 yields X unchanged.
- R8: Each operation is computed on signed operands at full width. A sum above 32767 gives 32767, and a sum below -32768 gives -32768.
- R9: Count the runtime clocks from 0, starting at the first clock with runMode high. Clock k fires exactly when mask bit (k mod 16) is 1.
- R10: Take a clock edge where the cell fires. After that edge, resOut holds the result for the operands present at that edge, and resValid is 1.
- R11: Take a clock edge where the cell does not fire, in either mode. After that edge, resValid is 0 and resOut is unchanged.
- R12: Leaving runtime mode and entering it again restarts the mask walk at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runMode | input | 1 | 1 = runtime, 0 = configuration |
| cfgWe | input | 1 | Setup write strobe |
| cfgAddr | input | 2 | Setup register select |
| cfgData | input | 16 | Setup write value |
| xIn | input | 16 | Signed operand X |
| yIn | input | 16 | Signed operand Y |
| wIn | input | 16 | Signed operand W |
| resOut | output | 16 | Signed clamped result |
| resValid | output | 1 | Result updated on the last edge |

## Verification
Every result lags its operands by one register. The bench therefore applies operands on the falling edge, lets one rising edge pass, and reads resOut and resValid on the next falling edge. The bench model keeps its own copy of the mask pointer. It resets that copy whenever it drops runMode, so each check knows whether that edge should have fired (R9, R12). A setup write takes effect at the rising edge that samples it, so the first runtime step after a write already uses the new value.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    OP_MAC  = 2'd0,
    OP_DUAL = 2'd1,
    OP_ADD  = 2'd2,
    OP_PASS = 2'd3
  } peOp_e;

  typedef struct packed {
    logic  fire;
    peOp_e op;
  } peStrobe_t;
endpackage

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SCHED_LEN = 16,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runMode,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  output peStrobe_t         strobe,
  output logic [DATA_W-1:0] coefA,
  output logic [DATA_W-1:0] coefB
);
  localparam int PTR_W = (SCHED_LEN > 1) ? $clog2(SCHED_LEN) : 1;
  localparam logic [ADDR_W-1:0] ADDR_A    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_B    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_OP   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(3);
  localparam logic [PTR_W-1:0]  PTR_LAST  = PTR_W'(SCHED_LEN - 1);

  logic [DATA_W-1:0]    coefAReg, coefBReg;
  peOp_e                opReg;
  logic [SCHED_LEN-1:0] maskReg;
  logic [PTR_W-1:0]     schedPtr;
  logic                 cfgWrite;

  assign cfgWrite = cfgWe && !runMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefAReg <= '0;
      coefBReg <= '0;
      opReg    <= OP_MAC;
      maskReg  <= '0;
    end else if (cfgWrite) begin
      case (cfgAddr)
        ADDR_A:    coefAReg <= cfgData;
        ADDR_B:    coefBReg <= cfgData;
        ADDR_OP:   opReg    <= peOp_e'(cfgData[1:0]);
        ADDR_MASK: maskReg  <= SCHED_LEN'(cfgData);
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              schedPtr <= '0;
    else if (!runMode)      schedPtr <= '0;
    else if (schedPtr == PTR_LAST) schedPtr <= '0;
    else                    schedPtr <= schedPtr + 1'b1;
  end

  always_comb begin
    strobe.fire = runMode && maskReg[schedPtr];
    strobe.op   = opReg;
  end

  assign coefA = coefAReg;
  assign coefB = coefBReg;

  assert_ptr_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
    !runMode |=> schedPtr == '0);

  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    runMode |=> $stable(coefAReg) && $stable(coefBReg) && $stable(opReg) && $stable(maskReg));

  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    runMode && (schedPtr != PTR_LAST) |=> schedPtr == $past(schedPtr) + 1'b1);
endmodule

// File: rtl/pe_datapath.sv
module pe_datapath
  import pe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  peStrobe_t         strobe,
  input  logic [DATA_W-1:0] coefA,
  input  logic [DATA_W-1:0] coefB,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] wIn,
  output logic [DATA_W-1:0] resOut,
  output logic              resValid
);
  localparam int ACC_W = 2 * DATA_W + 2;
  localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MIN_V = -ACC_W'(64'sd1 <<< (DATA_W - 1));

  logic signed [ACC_W-1:0] xExt, yExt, wExt, aExt, bExt;
  logic signed [ACC_W-1:0] accSum;
  logic [DATA_W-1:0]       clamped;

  always_comb begin
    xExt = ACC_W'($signed(xIn));
    yExt = ACC_W'($signed(yIn));
    wExt = ACC_W'($signed(wIn));
    aExt = ACC_W'($signed(coefA));
    bExt = ACC_W'($signed(coefB));
    case (strobe.op)
      OP_MAC:  accSum = xExt * aExt + yExt;
      OP_DUAL: accSum = xExt * aExt + yExt * bExt + wExt;
      OP_ADD:  accSum = xExt + yExt;
      default: accSum = xExt;
    endcase
    if (accSum > MAX_V)      clamped = DATA_W'(MAX_V);
    else if (accSum < MIN_V) clamped = DATA_W'(MIN_V);
    else                     clamped = accSum[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resOut   <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strobe.fire;
      if (strobe.fire) resOut <= clamped;
    end
  end

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> !resValid && $stable(resOut));

  assert_fire_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> resValid);

  assert_pass_exact_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire && strobe.op == OP_PASS |=> resOut == $past(xIn));
endmodule

// File: rtl/pe_elem.sv
module pe_elem
  import pe_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SCHED_LEN = 16,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runMode,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] wIn,
  output logic [DATA_W-1:0] resOut,
  output logic              resValid
);
  peStrobe_t         strobe;
  logic [DATA_W-1:0] coefA, coefB;

  pe_ctrl #(.DATA_W(DATA_W), .SCHED_LEN(SCHED_LEN), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .runMode(runMode), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strobe(strobe), .coefA(coefA), .coefB(coefB)
  );

  pe_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .coefA(coefA), .coefB(coefB),
    .xIn(xIn), .yIn(yIn), .wIn(wIn), .resOut(resOut), .resValid(resValid)
  );
endmodule

// File: tb/test_pe_elem.sv
module test_pe_elem;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runMode = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic [15:0] xIn = '0, yIn = '0, wIn = '0;
  logic [15:0] resOut;
  logic        resValid;

  int checks = 0;
  int errors = 0;
  int mA = 0, mB = 0, mOp = 0, mPtr = 0;
  logic [15:0] mMask = '0;
  logic [15:0] lastOut = '0;

  always #10 clk = ~clk;

  pe_elem i_pe_elem (
    .clk(clk), .rstN(rstN), .runMode(runMode), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .xIn(xIn), .yIn(yIn), .wIn(wIn),
    .resOut(resOut), .resValid(resValid)
  );

  function automatic int model(int op, int a, int b, int x, int y, int w);
    longint s;
    case (op)
      0: s = longint'(x) * a + y;
      1: s = longint'(x) * a + longint'(y) * b + w;
      2: s = longint'(x) + y;
      default: s = x;
    endcase
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(int addr, int data);
    runMode = 1'b0;
    cfgWe = 1'b1; cfgAddr = 2'(addr); cfgData = 16'(data);
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0;
    mPtr = 0;
    case (addr)
      0: mA = int'($signed(16'(data)));
      1: mB = int'($signed(16'(data)));
      2: mOp = data & 3;
      default: mMask = 16'(data);
    endcase
    chk("R11 config cycle valid", int'(resValid), 0);
    chk("R11 config cycle hold", int'(resOut), int'(lastOut));
  endtask

  task automatic runStep(int x, int y, int w, string tag);
    logic fire;
    int exp;
    runMode = 1'b1;
    xIn = 16'(x); yIn = 16'(y); wIn = 16'(w);
    fire = mMask[mPtr];
    mPtr = (mPtr + 1) % 16;
    @(posedge clk); @(negedge clk);
    if (fire) begin
      exp = model(mOp, mA, mB, x, y, w);
      chk({tag, " R10 valid"}, int'(resValid), 1);
      chk(tag, int'($signed(resOut)), exp);
      lastOut = 16'(exp);
    end else begin
      chk({tag, " R11 valid"}, int'(resValid), 0);
      chk({tag, " R11 hold"}, int'(resOut), int'(lastOut));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int vals[8] = '{0, 1, -1, 7, -300, 12345, 32767, -32768};
    int coefs[3][2] = '{'{3, -2}, '{32767, 32767}, '{-32768, 5}};
    string opTag[4] = '{"R4", "R5", "R6", "R7"};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset out", int'(resOut), 0);
    chk("R1 reset valid", int'(resValid), 0);
    for (int i = 0; i < 4; i++) runStep(100, 200, 300, "R1 zero mask");

    cfgWrite(3, 16'hFFFF);
    cfgWrite(0, 5);
    cfgWrite(2, 0);
    runStep(2, 1, 0, "R2 coef A");
    cfgWrite(1, -4);
    cfgWrite(2, 1);
    runStep(2, 3, 10, "R2 coef B");

    for (int c = 0; c < 3; c++) begin
      cfgWrite(0, coefs[c][0]);
      cfgWrite(1, coefs[c][1]);
      for (int op = 0; op < 4; op++) begin
        cfgWrite(2, op);
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            runStep(vals[i], vals[j], vals[(i + j) % 8], {opTag[op], " R8 sweep"});
      end
    end

    cfgWrite(0, 3);
    cfgWrite(2, 0);
    runMode = 1'b1;
    cfgWe = 1'b1; cfgAddr = 2'd0; cfgData = 16'd100;
    runStep(4, 1, 0, "R3 write during run");
    cfgAddr = 2'd2; cfgData = 16'd3;
    runStep(5, 1, 0, "R3 write during run");
    cfgWe = 1'b0;
    runStep(6, 1, 0, "R3 setup unchanged");

    cfgWrite(2, 2);
    cfgWrite(3, 16'hA5C3);
    for (int k = 0; k < 40; k++) runStep(k * 11 - 50, k, 0, "R9 mask walk");
    cfgWrite(3, 16'h0006);
    for (int k = 0; k < 5; k++) runStep(k + 1, 1000, 0, "R12 restart");
    cfgWrite(3, 16'h0001);
    runStep(7, 7, 0, "R12 restart bit0");
    runStep(9, 9, 0, "R12 restart bit1");

    cfgWrite(2, 2);
    cfgWrite(3, 16'hFFFF);
    runStep(32767, 1, 0, "R8 high clamp");
    runStep(-32768, -1, 0, "R8 low clamp");
    runStep(32767, -1, 0, "R8 no clamp");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule